// File: doc/BRIEF.md
# Selectable Clock-Counted Reference Delay

This block watches a single-bit timing input, sampled on the rising edge of a system clock. When it sees the chosen active edge of that input, it waits a whole number of clock cycles and then emits a reference pulse one cycle wide. A downstream phase comparator uses this pulse as its reference. Two control bits set the delay. The edge-select bit picks which input transition is active and also which pair of delays applies. The slow-select bit picks the shorter or the longer delay of that pair.

Each detected edge is placed into a pending-event shift line at the position that matches the delay chosen at that moment. Several edges can therefore be in flight at once, and a later change to the controls does not disturb events already queued. The block also outputs a delayed copy of the input level. That copy lags the sampled input by the delay that the present control setting selects.

Top module: `ref_delay_gen`

## Requirements
- R1: The input is sampled on each rising clock edge. With edge_sel = 1, a sampled high-to-low transition is the active edge, and a low-to-high transition produces no pulse.
- R2: With edge_sel = 0, a sampled low-to-high transition is the active edge, and a high-to-low transition produces no pulse.
- R3: With {edge_sel, slow_sel} = 2'b11, the delay D is 9 cycles. If the clock edge that first samples the new input level is edge k, then ref_pulse is high in the cycle that follows edge k+D.
- R4: With {edge_sel, slow_sel} = 2'b10, D is 15 cycles, using the same timing as R3.
- R5: With {edge_sel, slow_sel} = 2'b01, D is 26 cycles, using the same timing as R3.
- R6: With {edge_sel, slow_sel} = 2'b00, D is 32 cycles, using the same timing as R3.
- R7: Each active edge produces ref_pulse high for exactly one cycle. ref_pulse is never high without an active edge behind it.
- R8: The polarity and delay for an edge come from the control values present in the cycle after the edge is sampled (the detection cycle). Changing the controls later does not move or cancel that edge's pulse.
- R9: Active edges that arrive while earlier ones are still pending each get their own pulse at their own due cycle. If two edges fall due in the same cycle, they yield a single one-cycle pulse.
- R10: After clock edge m, tin_dly equals the input level sampled at edge m−D, where D comes from the controls present before edge m. Samples taken during reset count as low.
- R11: A synchronous reset clears the sampled history to low and discards all pending events. It holds ref_pulse and tin_dly low. Because the history is low, a high input sampled right after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tin | input | 1 | Timing input whose active edge starts a delay |
| edge_sel | input | 1 | 1: falling edge active, short pair (9/15); 0: rising edge active, long pair (26/32) |
| slow_sel | input | 1 | 1: shorter delay of the pair; 0: longer delay |
| ref_pulse | output | 1 | One-cycle reference event, D cycles after the active edge |
| tin_dly | output | 1 | Input level delayed by the selected D cycles |

## Verification
The bench builds the block with its default delays of 9, 15, 26 and 32. This makes the pending line and the level history 32 entries deep, so all four delay taps are exercised, including the deepest slot at index 31 and the single-cycle-aged slot. An arithmetic model in the bench, running cycle by cycle, schedules every expected pulse and level sample. The stimulus sweeps all four control settings with isolated pulses of several widths, ignored opposite edges, dense toggling that keeps many events pending, control changes while counts are running (which also force pulses from different delays to coincide), and a reset that lands while events are queued.

// File: rtl/ref_delay_pkg.sv
package ref_delay_pkg;

   // Control word formed as {edge_sel, slow_sel}
   typedef enum logic [1:0] {
      MODE_RISE_LONG  = 2'b00,
      MODE_RISE_SHORT = 2'b01,
      MODE_FALL_LONG  = 2'b10,
      MODE_FALL_SHORT = 2'b11
   } dly_mode_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rdg_edge_det.sv
module rdg_edge_det #(
   parameter int unsigned DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             din,
   input  logic             fall_active,
   output logic [DEPTH-1:0] hist,
   output logic             hit
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rdg_edge_det: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] hist_q;

   // hist_q[0] holds the newest sample, hist_q[i] the sample i edges older
   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= {hist_q[DEPTH-2:0], din};
   end

   assign hist = hist_q;
   assign hit  = fall_active ? (hist_q[1] & ~hist_q[0])
                             : (~hist_q[1] & hist_q[0]);

endmodule

// File: rtl/rdg_pending_line.sv
module rdg_pending_line #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inject,
   input  logic [IW-1:0]    slot,
   output logic [DEPTH-1:0] line,
   output logic             pulse
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rdg_pending_line: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] line_q;
   logic [DEPTH-1:0] line_d;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic ins;
      assign ins = inject && (slot == IW'(i));
      if (i == DEPTH - 1) begin : g_top
         assign line_d[i] = ins;
      end else begin : g_mid
         assign line_d[i] = line_q[i+1] | ins;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) line_q <= '0;
      else     line_q <= line_d;
   end

   assign line  = line_q;
   assign pulse = line_q[0];

endmodule

// File: rtl/rdg_level_tap.sv
module rdg_level_tap #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DEPTH-1:0] hist,
   input  logic [IW-1:0]    tap,
   output logic             level
);

   logic level_q;

   always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b0;
      else     level_q <= hist[tap];
   end

   assign level = level_q;

endmodule

// File: rtl/ref_delay_gen.sv
module ref_delay_gen #(
   parameter int unsigned DLY_FALL_SHORT = 9,
   parameter int unsigned DLY_FALL_LONG  = 15,
   parameter int unsigned DLY_RISE_SHORT = 26,
   parameter int unsigned DLY_RISE_LONG  = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic tin,
   input  logic edge_sel,
   input  logic slow_sel,
   output logic ref_pulse,
   output logic tin_dly
);

   import ref_delay_pkg::*;

   localparam int unsigned MAXD = max4(DLY_FALL_SHORT, DLY_FALL_LONG,
                                       DLY_RISE_SHORT, DLY_RISE_LONG);
   localparam int unsigned IW   = $clog2(MAXD);
   localparam int unsigned DW   = $clog2(MAXD + 1);

   if (DLY_FALL_SHORT < 1 || DLY_FALL_LONG < 1 ||
       DLY_RISE_SHORT < 1 || DLY_RISE_LONG < 1) begin : g_bad_dly
      $error("ref_delay_gen: every delay must be at least one cycle");
   end
   if (MAXD < 2) begin : g_bad_max
      $error("ref_delay_gen: the longest delay must be at least two cycles");
   end

   dly_mode_e        mode;
   logic [DW-1:0]    dsel;
   logic [IW-1:0]    tap_idx;
   logic [MAXD-1:0]  hist_w;
   logic [MAXD-1:0]  line_w;
   logic             hit_w;

   assign mode = dly_mode_e'({edge_sel, slow_sel});

   always_comb begin
      unique case (mode)
         MODE_FALL_SHORT: dsel = DW'(DLY_FALL_SHORT);
         MODE_FALL_LONG:  dsel = DW'(DLY_FALL_LONG);
         MODE_RISE_SHORT: dsel = DW'(DLY_RISE_SHORT);
         default:         dsel = DW'(DLY_RISE_LONG);
      endcase
   end

   // A slot index of D-1 at injection reaches the output D edges after sampling
   assign tap_idx = IW'(dsel - DW'(1));

   rdg_edge_det #(.DEPTH(MAXD)) u_edge (
      .clk         (clk),
      .rst         (rst),
      .din         (tin),
      .fall_active (edge_sel),
      .hist        (hist_w),
      .hit         (hit_w)
   );

   rdg_pending_line #(.DEPTH(MAXD)) u_line (
      .clk    (clk),
      .rst    (rst),
      .inject (hit_w),
      .slot   (tap_idx),
      .line   (line_w),
      .pulse  (ref_pulse)
   );

   rdg_level_tap #(.DEPTH(MAXD)) u_tap (
      .clk   (clk),
      .rst   (rst),
      .hist  (hist_w),
      .tap   (tap_idx),
      .level (tin_dly)
   );

endmodule

// File: rtl/ref_delay_chk.sv
module ref_delay_chk #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned IW    = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             tin,
   input logic [DEPTH-1:0] hist,
   input logic             hit,
   input logic [IW-1:0]    tap_idx,
   input logic [DEPTH-1:0] line,
   input logic             ref_pulse,
   input logic             tin_dly
);

   // R1: the newest history entry is the input seen at the last edge
   p_sample_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (hist[0] == $past(tin)));

   // R8: a detected edge lands in the slot chosen in its detection cycle
   p_inject_r8: assert property (@(posedge clk) disable iff (rst)
      hit |=> line[$past(tap_idx)]);

   // R7: a pulse always comes from a queued event or a one-cycle injection
   p_pulse_src_r7: assert property (@(posedge clk) disable iff (rst)
      ref_pulse |-> $past(line[1] || (hit && (tap_idx == '0))));

   // R10: the level copy follows the tapped history entry
   p_level_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (tin_dly == $past(hist[tap_idx])));

   // R11: reset silences both outputs on the next edge
   p_reset_quiet_r11: assert property (@(posedge clk)
      rst |=> (!ref_pulse && !tin_dly));

endmodule

bind ref_delay_gen ref_delay_chk #(.DEPTH(MAXD), .IW(IW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tin       (tin),
   .hist      (hist_w),
   .hit       (hit_w),
   .tap_idx   (tap_idx),
   .line      (line_w),
   .ref_pulse (ref_pulse),
   .tin_dly   (tin_dly)
);

// File: tb/ref_delay_gen_tb.sv
module ref_delay_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 64;
   localparam int WD_LIMIT   = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tin = 1'b0;
   logic edge_sel = 1'b0;
   logic slow_sel = 1'b0;
   logic ref_pulse;
   logic tin_dly;

   int    n_chk = 0;
   int    n_err = 0;
   int    cyc   = 0;
   bit    running = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R11";

   logic due  [WIN];
   logic samp [WIN];
   logic h0 = 1'b0;
   logic h1 = 1'b0;
   logic exp_dly = 1'b0;
   logic [15:0] lf = 16'hACE1;

   ref_delay_gen u_dut (
      .clk       (clk),
      .rst       (rst),
      .tin       (tin),
      .edge_sel  (edge_sel),
      .slow_sel  (slow_sel),
      .ref_pulse (ref_pulse),
      .tin_dly   (tin_dly)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int dly_of(input logic e, input logic s);
      if (e) return s ? 9 : 15;
      return s ? 26 : 32;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: cycle %0d actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   // Arithmetic reference model, advanced at each rising edge
   always @(posedge clk) begin
      int d;
      logic act;
      cyc = cyc + 1;
      if (rst) begin
         for (int i = 0; i < WIN; i++) begin
            due[i]  = 1'b0;
            samp[i] = 1'b0;
         end
         h0 = 1'b0;
         h1 = 1'b0;
         exp_dly = 1'b0;
      end else begin
         d   = dly_of(edge_sel, slow_sel);
         act = edge_sel ? (h1 & ~h0) : (~h1 & h0);
         if (act) due[(cyc - 1 + d) % WIN] = 1'b1;
         exp_dly = samp[(cyc + WIN - d) % WIN];
         samp[cyc % WIN] = tin;
         h1 = h0;
         h0 = tin;
      end
   end

   // Output comparison away from the active edge
   always @(negedge clk) begin
      if (running) begin
         chk(cur_tag, ref_pulse, due[cyc % WIN]);
         due[cyc % WIN] = 1'b0;
         chk("R10", tin_dly, exp_dly);
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > WD_LIMIT) begin
         n_chk++;
         n_err++;
         $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input logic e, input logic s);
      edge_sel = e;
      slow_sel = s;
   endtask

   task automatic lf_step();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   initial begin
      @(posedge clk);
      running = 1'b1;

      // R11: reset state, outputs held low
      cur_tag = "R11";
      idle(4);
      chk("R11", ref_pulse, 1'b0);
      chk("R11", tin_dly, 1'b0);
      rst = 1'b0;
      idle(2);

      // R3..R6: isolated pulses of several widths in every mode
      for (int md = 3; md >= 0; md--) begin
         set_mode(md[1], md[0]);
         case (md)
            3: cur_tag = "R3";
            2: cur_tag = "R4";
            1: cur_tag = "R5";
            default: cur_tag = "R6";
         endcase
         idle(36);
         for (int w = 1; w <= 4; w++) begin
            tin = 1'b1;
            idle(w);
            tin = 1'b0;
            idle(38);
         end
      end

      // R1: rising edge ignored when falling edge is active
      cur_tag = "R1";
      set_mode(1'b1, 1'b1);
      idle(36);
      tin = 1'b1;
      idle(20);
      chk("R1", ref_pulse, 1'b0);
      tin = 1'b0;
      idle(20);

      // R2: falling edge ignored when rising edge is active
      cur_tag = "R2";
      set_mode(1'b0, 1'b1);
      idle(36);
      tin = 1'b1;
      idle(36);
      tin = 1'b0;
      idle(36);
      chk("R2", ref_pulse, 1'b0);

      // R7: single event, single pulse
      cur_tag = "R7";
      set_mode(1'b1, 1'b0);
      idle(36);
      tin = 1'b1;
      idle(3);
      tin = 1'b0;
      idle(30);

      // R9: dense toggling keeps many events in flight
      cur_tag = "R9";
      for (int md = 0; md < 4; md++) begin
         set_mode(md[1], md[0]);
         idle(36);
         for (int i = 0; i < 30; i++) begin
            tin = ~tin;
            idle(1 + (i % 3));
         end
         tin = 1'b0;
         idle(40);
      end

      // R8: controls changed while counts are running
      cur_tag = "R8";
      set_mode(1'b1, 1'b1);
      idle(36);
      tin = 1'b1;
      idle(2);
      tin = 1'b0;
      idle(1);
      for (int i = 0; i < 12; i++) begin
         set_mode(i[1], i[0]);
         idle(1);
      end
      idle(40);
      for (int i = 0; i < 600; i++) begin
         lf_step();
         tin = lf[0];
         if (lf[5:3] == 3'b000) set_mode(lf[7], lf[9]);
         idle(1);
      end
      tin = 1'b0;
      idle(40);

      // R11: reset with events pending discards them
      cur_tag = "R11";
      set_mode(1'b0, 1'b0);
      idle(36);
      tin = 1'b1;
      idle(4);
      tin = 1'b0;
      idle(6);
      rst = 1'b1;
      idle(2);
      chk("R11", ref_pulse, 1'b0);
      rst = 1'b0;
      idle(40);

      // R11: high input sampled right after reset counts as a rising edge
      rst = 1'b1;
      tin = 1'b1;
      idle(3);
      rst = 1'b0;
      idle(40);
      tin = 1'b0;
      idle(40);

      running = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule